// File: doc/BRIEF.md
# ROM-Sequenced Serial Message Transmitter

This block repeats a fixed text message on an asynchronous serial line without any shift register. Each line level of every frame (start bit, eight data bits, stop bit) is laid out ahead of time in a one-bit-wide ROM. A free-running slot counter reads that ROM one entry per bit period. The ROM image is computed at elaboration from a string parameter. Slots left over after the last frame that fits hold the idle level.

The surrounding logic supplies a one-cycle baud enable pulse at the bit rate. For example, a 1.8432 MHz reference divided by eight gives 230400 slots per second. Each pulse moves the slot counter forward and loads the current ROM bit into a register that drives the line. The line therefore changes only on a clock edge, and it trails the slot address by one bit period. With the default 7-bit counter, a cycle has 128 slots and holds up to twelve characters, after which the message starts again.

Top module: `msg_rom_tx`

## Requirements
- R1: While `rst_n` is low, `tx` is 1 and the slot position returns to 0. The first baud tick after reset therefore emits slot 0.
- R2: Each baud tick advances the slot position by one. After 2**SLOT_W ticks the position wraps to 0, and the same bit sequence repeats exactly.
- R3: A clock edge with `baud_en` low changes neither `tx` nor the slot position.
- R4: Character k occupies slots 10k to 10k+9. Slot 10k is the start bit (0), slots 10k+1 to 10k+8 carry data bits 0 to 7 (least significant first), and slot 10k+9 is the stop bit (1).
- R5: Characters are sent in string order, leftmost first. Character k of the message is the k-th character from the left of `MSG`.
- R6: Every slot after the last complete frame holds 1, the idle level.
- R7: At most floor(2**SLOT_W / 10) characters are stored. Characters beyond that limit are dropped, and their slots hold the idle level.
- R8: After the n-th baud tick since reset, `tx` equals the ROM bit of slot (n-1) mod 2**SLOT_W. This is one bit period behind the slot address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_en | input | 1 | One-cycle pulse per bit period |
| tx | output | 1 | Registered serial line |

## Verification
The bench builds two instances that run side by side from the same ticks. The first uses the default 7-bit counter with a twelve-character message, so all 120 frame slots and the 8-slot idle tail are walked, and two full wraps are covered. The second uses a 5-bit counter with a four-character message, which places the fourth character beyond the three-frame capacity and brings the drop rule within reach in only 32 slots. Idle gaps of varying length between ticks exercise the hold behaviour. A reset in mid-message shows the return to slot 0.

// File: rtl/msgtx_pkg.sv
// Package: shared frame layout constants and the per-slot bit rule.
// Assumes 8 data bits, one start and one stop bit, no parity.
package msgtx_pkg;
    localparam int  FRAME_SLOTS = 10;
    localparam int  DATA_BITS   = 8;
    localparam logic START_LVL  = 1'b0;
    localparam logic STOP_LVL   = 1'b1;
    localparam logic IDLE_LVL   = 1'b1;

    // Line level at position pos (0..9) of the frame carrying ch.
    function automatic logic frame_bit(input logic [7:0] ch, input int pos);
        if (pos == 0)
            return START_LVL;
        else if (pos == FRAME_SLOTS - 1)
            return STOP_LVL;
        else
            return ch[pos-1];
    endfunction
endpackage

// File: rtl/slot_counter.sv
// Slot counter: free-running position within the message cycle.
// Assumes adv is a single-cycle enable; wraps naturally at 2**W.
module slot_counter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] slot
);
    // Step the position once per enable; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot <= '0;
        else if (adv)
            slot <= slot + 1'b1;
    end
endmodule

// File: rtl/frame_rom.sv
// Frame ROM: one line-level bit per slot, computed at elaboration.
// Assumes MSG holds MSG_LEN characters, leftmost in the top byte.
module frame_rom #(
    parameter int                    SLOT_W  = 7,
    parameter int                    MSG_LEN = 11,
    parameter logic [8*MSG_LEN-1:0]  MSG     = "No computer"
) (
    input  logic [SLOT_W-1:0] addr,
    output logic              bit_o
);
    import msgtx_pkg::*;

    localparam int SLOTS    = 1 << SLOT_W;
    localparam int CAPACITY = SLOTS / FRAME_SLOTS;
    localparam int N_FRAMES = (MSG_LEN < CAPACITY) ? MSG_LEN : CAPACITY;

    // Lay out every slot: frames first, idle level afterwards.
    function automatic logic [SLOTS-1:0] build_image();
        logic [SLOTS-1:0] img;
        img = '0;
        for (int s = 0; s < SLOTS; s++) begin
            int k;
            int p;
            k = s / FRAME_SLOTS;
            p = s % FRAME_SLOTS;
            if (k < N_FRAMES)
                img[s] = frame_bit(MSG[8*(MSG_LEN-1-k) +: 8], p);
            else
                img[s] = IDLE_LVL;
        end
        return img;
    endfunction

    localparam logic [SLOTS-1:0] IMAGE = build_image();

    // Combinational read of the selected slot.
    always_comb bit_o = IMAGE[addr];
endmodule

// File: rtl/tx_retimer.sv
// Output register: captures the ROM bit so the line moves only on an edge.
// Assumes load is the same enable that advances the address.
module tx_retimer (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic d,
    output logic q
);
    import msgtx_pkg::*;

    // Hold the line idle in reset; take the new bit on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= IDLE_LVL;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/msg_rom_tx.sv
// Top: ROM-replayed serial message. Counter addresses the frame ROM,
// the retimer drives the line one bit period behind the address.
// Assumes baud_en is a clean one-cycle pulse at the bit rate.
module msg_rom_tx #(
    parameter int                    SLOT_W  = 7,
    parameter int                    MSG_LEN = 11,
    parameter logic [8*MSG_LEN-1:0]  MSG     = "No computer"
) (
    input  logic clk,
    input  logic rst_n,
    input  logic baud_en,
    output logic tx
);
    import msgtx_pkg::*;

    localparam int SLOTS    = 1 << SLOT_W;
    localparam int CAPACITY = SLOTS / FRAME_SLOTS;
    localparam int N_FRAMES = (MSG_LEN < CAPACITY) ? MSG_LEN : CAPACITY;

    logic [SLOT_W-1:0] slot_q;
    logic              rom_bit;

    slot_counter #(.W(SLOT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (baud_en),
        .slot (slot_q)
    );

    frame_rom #(.SLOT_W(SLOT_W), .MSG_LEN(MSG_LEN), .MSG(MSG)) u_rom (
        .addr (slot_q),
        .bit_o(rom_bit)
    );

    tx_retimer u_out (
        .clk  (clk),
        .rst_n(rst_n),
        .load (baud_en),
        .d    (rom_bit),
        .q    (tx)
    );
endmodule

// File: rtl/msg_rom_tx_chk.sv
// Checker: temporal properties of the slot position and the line.
module msg_rom_tx_chk #(
    parameter int SLOT_W  = 7,
    parameter int N_CHARS = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              baud_en,
    input logic              tx,
    input logic [SLOT_W-1:0] slot
);
    localparam int SLOTS = 1 << SLOT_W;

    // R1: reset leaves the line idle and the position at zero
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (tx == 1'b1 && slot == '0));

    // R3: no tick, no movement
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_en |=> ($stable(tx) && $stable(slot)));

    // R2: each tick steps the position by one, wrapping
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        baud_en |=> slot == SLOT_W'($past(slot) + 1'b1));

    // R4: start slot of a stored frame drives 0 next
    a_r4_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_en && (int'(slot) % 10 == 0) && (int'(slot) / 10 < N_CHARS))
        |=> tx == 1'b0);

    // R4: stop slot of a stored frame drives 1 next
    a_r4_stop_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_en && (int'(slot) % 10 == 9) && (int'(slot) / 10 < N_CHARS))
        |=> tx == 1'b1);

    // R6: tail slots after the last frame drive the idle level
    a_r6_idle_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_en && int'(slot) >= N_CHARS * 10 && int'(slot) < SLOTS)
        |=> tx == 1'b1);
endmodule

bind msg_rom_tx msg_rom_tx_chk #(.SLOT_W(SLOT_W), .N_CHARS(N_FRAMES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .baud_en(baud_en),
    .tx     (tx),
    .slot   (slot_q)
);

// File: tb/test_msg_rom_tx.sv
// Bench: two instances, table-driven tick walk, then directed reset test.
module test_msg_rom_tx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic baud_en = 1'b0;
    logic tx_a, tx_b;

    int errors = 0;
    int checks = 0;
    int pa = 0;   // expected slot of instance A
    int pb = 0;   // expected slot of instance B
    int ticks = 0;

    always #10 clk = ~clk;   // 50 MHz

    msg_rom_tx #(.SLOT_W(7), .MSG_LEN(12), .MSG("Go!123abcXYZ")) i_msg_rom_tx (
        .clk(clk), .rst_n(rst_n), .baud_en(baud_en), .tx(tx_a));

    msg_rom_tx #(.SLOT_W(5), .MSG_LEN(4), .MSG("wxyz")) i_msg_rom_tx_over (
        .clk(clk), .rst_n(rst_n), .baud_en(baud_en), .tx(tx_b));

    localparam byte MSG_A [12] = '{"G","o","!","1","2","3","a","b","c","X","Y","Z"};
    localparam byte MSG_B [4]  = '{"w","x","y","z"};

    // Stimulus table: ticks per step and idle cycles before each tick.
    localparam int N_STEPS = 6;
    localparam int STEP_TICKS [N_STEPS] = '{10, 1, 37, 72, 8, 128};
    localparam int STEP_GAP   [N_STEPS] = '{0, 3, 1, 0, 5, 2};

    function automatic logic exp_a(input int s);
        int k, p;
        k = s / 10; p = s % 10;
        if (k >= 12) return 1'b1;
        if (p == 0) return 1'b0;
        if (p == 9) return 1'b1;
        return MSG_A[k][p-1];
    endfunction

    function automatic logic exp_b(input int s);
        int k, p;
        k = s / 10; p = s % 10;
        if (k >= 3) return 1'b1;       // 32 slots hold only three frames
        if (p == 0) return 1'b0;
        if (p == 9) return 1'b1;
        return MSG_B[k][p-1];
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: tx=%0b expected %0b (tick %0d)", req, act, exp, ticks);
        end
    endtask

    task automatic tick();
        @(negedge clk) baud_en = 1'b1;
        @(negedge clk) baud_en = 1'b0;
        ticks++;
    endtask

    task automatic tick_and_check();
        string ra, rb;
        tick();
        if (ticks > 128)          ra = "R2";
        else if (pa >= 120)       ra = "R6";
        else if (pa % 10 == 0 || pa % 10 == 9) ra = "R4";
        else                      ra = "R5";
        if (pb >= 30)             rb = "R7";
        else                      rb = "R8";
        chk(ra, tx_a, exp_a(pa));
        chk(rb, tx_b, exp_b(pb));
        pa = (pa + 1) % 128;
        pb = (pb + 1) % 32;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic ha, hb;
        repeat (3) @(negedge clk);
        chk("R1", tx_a, 1'b1);
        chk("R1", tx_b, 1'b1);
        rst_n = 1'b1;

        // Table walk: 256 ticks, two full cycles of A, eight of B.
        for (int st = 0; st < N_STEPS; st++) begin
            for (int t = 0; t < STEP_TICKS[st]; t++) begin
                ha = tx_a; hb = tx_b;
                for (int g = 0; g < STEP_GAP[st]; g++) begin
                    @(negedge clk);
                    chk("R3", tx_a, ha);   // no tick, line holds
                    chk("R3", tx_b, hb);
                end
                tick_and_check();
            end
        end

        // Directed: long gap mid-frame then the position resumes in order (R3).
        repeat (4) tick_and_check();
        ha = tx_a;
        repeat (20) @(negedge clk);
        chk("R3", tx_a, ha);
        tick_and_check();

        // Directed: reset mid-message returns to slot 0 (R1).
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk("R1", tx_a, 1'b1);
        chk("R1", tx_b, 1'b1);
        rst_n = 1'b1;
        pa = 0; pb = 0;
        tick();
        chk("R1", tx_a, 1'b0);            // slot 0 start bit
        chk("R1", tx_b, 1'b0);
        tick();
        chk("R5", tx_a, 1'b1);            // 'G' = 0x47, bit 0 = 1
        chk("R5", tx_b, 1'b1);            // 'w' = 0x77, bit 0 = 1
        tick();
        chk("R8", tx_a, 1'b1);            // 'G' bit 1 = 1
        tick();
        chk("R8", tx_a, 1'b1);            // 'G' bit 2 = 1
        tick();
        chk("R8", tx_a, 1'b0);            // 'G' bit 3 = 0

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule